// File: doc/BRIEF.md
# Shared-Port Fetch and Data Arbiter

This block sits in front of a single-port memory that serves both instruction fetch and load/store traffic in a five-stage in-order pipeline. Each cycle it decides who owns the port, steers address, write enable and write data through one multiplexer, and keeps the fetch side of the pipeline consistent when fetch loses. The memory-stage access is older than any fetch, so it always wins. The fetch that loses is retried on the next cycle.

The block owns the program counter and the fetch-to-decode register. When fetch is granted, the block captures the read word together with its PC and advances the PC. When fetch is refused, the PC and the captured word hold, the valid flag drops and a bubble flag goes to decode. Each refused cycle therefore delays the fetched instruction and everything behind it by exactly one cycle. When no data access is present, fetch runs every cycle. The memory is modelled with a combinational read and a write at the clock edge.

Top module: `umem_port_arbiter`

## Requirements
- R1: While reset is low and at the first cycle after it, the PC output equals RESET_PC, the decode valid flag is 0, the bubble flag is 0 and no stall is signalled.
- R2: In a cycle with no data request and fetch enabled, the port address equals the PC and fetch is granted. At the next edge the PC advances by PC_STEP, the decode register takes the read word and the old PC, and valid becomes 1.
- R3: A data request always owns the port. The port address equals the data address, and the stall output is 1 whenever fetch is enabled in that cycle.
- R4: After a stalled cycle the PC, the captured instruction and the captured PC are unchanged, valid is 0 and the bubble flag is 1.
- R5: A refused fetch is retried in the next cycle at the same PC, so each conflict cycle delays the instruction stream by exactly one cycle.
- R6: Write enable reaches the port only when a data request with its write flag is present. Fetch never writes.
- R7: When a store and a fetch target the same address in one cycle, the store is performed first, and the retried fetch captures the stored value.
- R8: The port enable is 1 exactly when a data request is present or fetch is enabled.
- R9: With fetch disabled, the PC holds, valid becomes 0 at the next edge, no stall and no bubble are signalled, and a data request is still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en_i | input | 1 | Fetch wants the port this cycle |
| dreq_i | input | 1 | Memory-stage load or store present |
| dwe_i | input | 1 | The data request is a store |
| daddr_i | input | ADDR_W | Data address |
| dwdata_i | input | DATA_W | Store data |
| mem_en_o | output | 1 | Port enable |
| mem_we_o | output | 1 | Port write enable |
| mem_addr_o | output | ADDR_W | Port address |
| mem_wdata_o | output | DATA_W | Port write data |
| mem_rdata_i | input | DATA_W | Port read data (same cycle) |
| stall_fetch_o | output | 1 | Fetch refused this cycle |
| pc_o | output | ADDR_W | Current program counter |
| ifid_instr_o | output | DATA_W | Captured instruction |
| ifid_pc_o | output | ADDR_W | PC of captured instruction |
| ifid_valid_o | output | 1 | Decode register holds a fresh instruction |
| dec_bubble_o | output | 1 | Decode receives a stall bubble |

## Verification
The bench builds the block with a 6-bit address, 32-bit data, a PC step of 1 and a reset PC of 4. With these values a 64-word memory image covers the whole address space, so the PC wraps many times in a short run. Stores can be aimed at the exact PC that is waiting to be refetched. A pseudo-random mix of loads, stores, and cycles with fetch enabled or disabled produces back-to-back conflicts and wrap-around. Every output is compared against a behavioural model on every cycle.

// File: rtl/umem_port_arbiter.sv
module umem_port_arbiter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PC_STEP = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [DATA_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en_i,
  input  logic              dreq_i,
  input  logic              dwe_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0] dwdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              stall_fetch_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ifid_instr_o,
  output logic [ADDR_W-1:0] ifid_pc_o,
  output logic              ifid_valid_o,
  output logic              dec_bubble_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic              fetch_win;
  logic [ADDR_W-1:0] pc_q;

  assign fetch_win     = fetch_en_i & ~dreq_i;
  assign stall_fetch_o = fetch_en_i & dreq_i;
  assign mem_en_o      = dreq_i | fetch_en_i;
  assign mem_we_o      = dreq_i & dwe_i;
  assign mem_addr_o    = dreq_i ? daddr_i : pc_q;
  assign mem_wdata_o   = dwdata_i;
  assign pc_o          = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q         <= RESET_PC;
      ifid_instr_o <= NOP_WORD;
      ifid_pc_o    <= RESET_PC;
      ifid_valid_o <= 1'b0;
      dec_bubble_o <= 1'b0;
    end else begin
      dec_bubble_o <= stall_fetch_o;
      ifid_valid_o <= fetch_win;
      if (fetch_win) begin
        pc_q         <= pc_q + STEP;
        ifid_instr_o <= mem_rdata_i;
        ifid_pc_o    <= pc_q;
      end
    end
  end

  // R2
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_i && !dreq_i) |=> (pc_o == $past(pc_o) + STEP) && ifid_valid_o);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fetch_o |=> $stable(pc_o) && $stable(ifid_instr_o) && !ifid_valid_o && dec_bubble_o);

  // R6
  fetch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dreq_i |-> !mem_we_o);

  // R3
  data_owns_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fetch_o |-> dreq_i && (mem_addr_o == daddr_i));

  // R9
  idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en_i |=> !ifid_valid_o && !dec_bubble_o && $stable(pc_o));
endmodule

// File: tb/umem_port_arbiter_tb.sv
`timescale 1ns/1ps
module umem_port_arbiter_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [AW-1:0] RPC = 6'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_en = 1'b0, dreq = 1'b0, dwe = 1'b0;
  logic [AW-1:0] daddr = '0;
  logic [DW-1:0] dwdata = '0;
  logic mem_en, mem_we, stall, ifid_valid, bubble;
  logic [AW-1:0] mem_addr, pc, ifid_pc;
  logic [DW-1:0] mem_wdata, mem_rdata, ifid_instr;

  logic [DW-1:0] mem [64];
  assign mem_rdata = mem[mem_addr];

  umem_port_arbiter #(.ADDR_W(AW), .DATA_W(DW), .PC_STEP(1), .RESET_PC(RPC),
                      .NOP_WORD(32'h13)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_en_i(fetch_en), .dreq_i(dreq), .dwe_i(dwe),
    .daddr_i(daddr), .dwdata_i(dwdata), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .stall_fetch_o(stall), .pc_o(pc), .ifid_instr_o(ifid_instr), .ifid_pc_o(ifid_pc),
    .ifid_valid_o(ifid_valid), .dec_bubble_o(bubble));

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [AW-1:0] m_pc = RPC, m_ifpc = RPC;
  logic [DW-1:0] m_instr = 32'h13;
  logic m_valid = 1'b0, m_bubble = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic fe, input logic dr, input logic we,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic fwin;
    @(negedge clk);
    fetch_en = fe; dreq = dr; dwe = we; daddr = a; dwdata = wd;
    #1;
    fwin = fe && !dr;
    chk("R3 stall", {31'b0, stall}, {31'b0, fe && dr});
    chk("R3 addr", {26'b0, mem_addr}, {26'b0, dr ? a : m_pc});
    chk("R6 we", {31'b0, mem_we}, {31'b0, dr && we});
    chk("R8 en", {31'b0, mem_en}, {31'b0, dr || fe});
    chk("R6 wdata", mem_wdata, wd);
    chk("R2 pc", {26'b0, pc}, {26'b0, m_pc});
    chk("R5 instr", ifid_instr, m_instr);
    chk("R5 ifpc", {26'b0, ifid_pc}, {26'b0, m_ifpc});
    chk("R4 valid", {31'b0, ifid_valid}, {31'b0, m_valid});
    chk("R4 bubble", {31'b0, bubble}, {31'b0, m_bubble});
    @(posedge clk);
    if (fwin) begin
      m_instr = mem[m_pc]; m_ifpc = m_pc; m_pc = m_pc + 6'd1;
    end
    m_valid = fwin;
    m_bubble = fe && dr;
    if (dr && we) mem[a] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [AW-1:0] tgt;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i * 7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", {26'b0, pc}, {26'b0, RPC});
    chk("R1 valid", {31'b0, ifid_valid}, 32'd0);
    chk("R1 bubble", {31'b0, bubble}, 32'd0);
    rst_n = 1'b1;
    // R2: free-running fetch
    for (int i = 0; i < 5; i++) step(1, 0, 0, '0, '0);
    // R3 R4 R5: single load, then two back-to-back
    step(1, 1, 0, 6'd40, '0);
    step(1, 0, 0, '0, '0);
    step(1, 1, 0, 6'd41, '0);
    step(1, 1, 1, 6'd42, 32'hCAFE_0001);
    step(1, 0, 0, '0, '0);
    step(1, 0, 0, '0, '0);
    // R7: store to the PC that fetch is waiting on
    tgt = m_pc;
    step(1, 1, 1, tgt, 32'hDEAD_BEEF);
    step(1, 0, 0, '0, '0);
    step(1, 0, 0, '0, '0);
    chk("R7 refetch", ifid_instr, 32'hDEAD_BEEF);
    chk("R7 refetch pc", {26'b0, ifid_pc}, {26'b0, tgt});
    // R6: write flag without request
    step(1, 0, 1, 6'd3, 32'h5555_AAAA);
    // R9: fetch idle, with and without data traffic
    step(0, 0, 0, '0, '0);
    step(0, 1, 1, 6'd50, 32'h0BAD_F00D);
    step(0, 1, 0, 6'd50, '0);
    step(1, 0, 0, '0, '0);
    step(1, 0, 0, '0, '0);
    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[4],
           lfsr[5] ? m_pc : lfsr[11:6], {lfsr, ~lfsr});
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule